// File: doc/BRIEF.md
# Compressed Cache Set with Shared Segment Pool

This block models one set of a cache whose tag store is decoupled from its data store. The set carries four tag entries. Behind them sits a shared pool of sixteen 8-byte segments, which is room for only two uncompressed 64-byte lines. Each resident line takes a run of 1 to 8 segments from the pool. A tag entry may therefore stay valid while the data behind it has been dropped. Each entry records the address tag, permission bits, a compressed flag and a size in segments. A recency stack orders the four entries.

A request either looks up a tag or fills a line. A lookup reports one of three outcomes:
- a hit;
- a match on a tag whose data is absent;
- a full tag miss.

The report also gives the matching entry's stack depth, compressed flag, size and permission. Downstream logic can use these to decide whether compression helped or hurt the access.

A fill chooses a target entry and installs the line with its size. It then frees segments by dropping the data of the least recent other resident lines until the new line fits. The tags of those lines stay valid.

Top module: `cset_segment_set`

## Requirements
- R1: After reset no tag is valid, `seg_used` is 0, `rsp_valid` is 0, and any lookup reports a tag miss.
- R2: A request accepted in cycle N gives `rsp_valid`=1 in cycle N+1. `rsp_kind` is encoded as 0 for a tag miss, 1 for a tag match with data absent, and 2 for a hit. It never takes the value 3. A fill reports the kind its tag had before the fill.
- R3: `seg_used` is the sum of the sizes of all resident lines and never exceeds 16.
- R4: A fill drops the data of other resident lines in order from least to most recent, stopping as soon as the new line fits. The dropped entries keep their tags, and later lookups on them report kind 1. Lookups never change residency.
- R5: A fill targets the entry whose tag matches. If no tag matches, it targets the lowest-numbered invalid entry. If every entry is valid, it targets the entry at the least recent stack position.
- R6: The stack holds a permutation of the depths 0 to 3, where 0 is most recent. Any lookup that matches a tag, and any fill, moves that entry to depth 0. `rsp_depth` gives the entry's depth before the move, and it is 0 on a tag miss.
- R7: A fill whose compressed flag is 0, or whose size is 0 or 8 or more, is stored as uncompressed with size 8. A stored size of 8 always has the compressed flag 0.
- R8: On a lookup that matches a tag, `rsp_cmp`, `rsp_size` and `rsp_perm` give that entry's stored fields. On a lookup tag miss they are 0. On a fill they give the values just stored.
- R9: A cycle with no request changes no state, and it is followed by `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_fill | input | 1 | 1 = fill, 0 = lookup |
| req_tag | input | TAG_W | Address tag |
| req_cmp | input | 1 | Fill line is compressed |
| req_size | input | SZ_W | Fill size in segments |
| req_perm | input | PERM_W | Fill permission bits |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_kind | output | 2 | 0 tag miss, 1 data absent, 2 hit |
| rsp_depth | output | IDX_W | Stack depth of the matching entry before the update |
| rsp_cmp | output | 1 | Compressed flag reported |
| rsp_size | output | SZ_W | Size reported, in segments |
| rsp_perm | output | PERM_W | Permission reported |
| seg_used | output | USE_W | Segments currently held by resident lines |

## Verification
A corrupted recency stack surfaces on the next matching lookup as a wrong `rsp_depth`. It also surfaces on the next full-set fill as the wrong victim, which a later lookup on the old tag exposes as an unexpected tag miss. A residency error is visible the next cycle on `seg_used`, and on the following lookup of the affected tag as the wrong kind. The stimulus walks the pool to exactly full, forces multi-line evictions, and refills a data-absent tag, so that each of these errors appears within one or two requests.

// File: rtl/cset_pkg.sv
package cset_pkg;
   typedef enum logic [1:0] {
      KIND_TAG_MISS    = 2'd0,
      KIND_DATA_ABSENT = 2'd1,
      KIND_HIT         = 2'd2
   } look_kind_e;
endpackage

// File: rtl/cset_tag_match.sv
module cset_tag_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 20,
   localparam int IDX_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]       valid,
   input  logic [WAYS*TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]      key,
   output logic                  any,
   output logic [IDX_W-1:0]      idx
);
   logic [WAYS-1:0] hit_vec;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = valid[w] && (tags[w*TAG_W +: TAG_W] == key);
   end

   always_comb begin
      idx = '0;
      for (int w = WAYS-1; w >= 0; w--) begin
         if (hit_vec[w]) idx = IDX_W'(w);
      end
   end

   assign any = |hit_vec;
endmodule

// File: rtl/cset_recency.sv
module cset_recency #(
   parameter int WAYS = 4,
   localparam int IDX_W = $clog2(WAYS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  touch,
   input  logic [IDX_W-1:0]      touch_idx,
   output logic [WAYS*IDX_W-1:0] pos_flat,
   output logic [WAYS*IDX_W-1:0] owner_flat
);
   logic [IDX_W-1:0] touched_pos;

   assign touched_pos = pos_flat[touch_idx*IDX_W +: IDX_W];

   for (genvar w = 0; w < WAYS; w++) begin : g_pos
      logic [IDX_W-1:0] pos_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pos_r <= IDX_W'(w);
         end else if (touch) begin
            if (touch_idx == IDX_W'(w))
               pos_r <= '0;
            else if (pos_r < touched_pos)
               pos_r <= pos_r + 1'b1;
         end
      end
      assign pos_flat[w*IDX_W +: IDX_W] = pos_r;
   end

   always_comb begin
      owner_flat = '0;
      for (int d = 0; d < WAYS; d++) begin
         for (int w = 0; w < WAYS; w++) begin
            if (pos_flat[w*IDX_W +: IDX_W] == IDX_W'(d))
               owner_flat[d*IDX_W +: IDX_W] = IDX_W'(w);
         end
      end
   end
endmodule

// File: rtl/cset_space_plan.sv
module cset_space_plan #(
   parameter int WAYS = 4,
   parameter int SEGS = 16,
   parameter int SZ_W = 4,
   localparam int IDX_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]       resident,
   input  logic [WAYS*SZ_W-1:0]  size_flat,
   input  logic [WAYS*IDX_W-1:0] owner_flat,
   input  logic [IDX_W-1:0]      target,
   input  logic [SZ_W-1:0]       new_size,
   output logic [WAYS-1:0]       evict
);
   int               acc;
   logic [IDX_W-1:0] who;

   always_comb begin
      acc   = 0;
      evict = '0;
      who   = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (resident[w] && (IDX_W'(w) != target))
            acc = acc + int'(size_flat[w*SZ_W +: SZ_W]);
      end
      // walk from the least recent depth towards the most recent
      for (int d = WAYS-1; d >= 0; d--) begin
         who = owner_flat[d*IDX_W +: IDX_W];
         if ((who != target) && resident[who] && (acc + int'(new_size) > SEGS)) begin
            evict[who] = 1'b1;
            acc = acc - int'(size_flat[who*SZ_W +: SZ_W]);
         end
      end
   end
endmodule

// File: rtl/cset_segment_set.sv
module cset_segment_set
   import cset_pkg::*;
#(
   parameter int TAG_W      = 20,
   parameter int PERM_W     = 2,
   parameter int WAYS       = 4,
   parameter int LINE_BYTES = 64,
   parameter int SEG_BYTES  = 8,
   parameter int DATA_LINES = 2,
   localparam int LINE_SEGS = LINE_BYTES / SEG_BYTES,
   localparam int SEGS      = DATA_LINES * LINE_SEGS,
   localparam int SZ_W      = $clog2(LINE_SEGS) + 1,
   localparam int IDX_W     = $clog2(WAYS),
   localparam int USE_W     = $clog2(SEGS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_fill,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic              req_cmp,
   input  logic [SZ_W-1:0]   req_size,
   input  logic [PERM_W-1:0] req_perm,
   output logic              rsp_valid,
   output logic [1:0]        rsp_kind,
   output logic [IDX_W-1:0]  rsp_depth,
   output logic              rsp_cmp,
   output logic [SZ_W-1:0]   rsp_size,
   output logic [PERM_W-1:0] rsp_perm,
   output logic [USE_W-1:0]  seg_used
);
   // elaboration-time parameter checks
   if (WAYS < 2 || (1 << IDX_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SEG_BYTES < 1 || (LINE_BYTES % SEG_BYTES) != 0) begin : g_bad_seg
      $error("LINE_BYTES must be a whole number of segments");
   end
   if (DATA_LINES < 1 || DATA_LINES > WAYS) begin : g_bad_lines
      $error("DATA_LINES must lie between 1 and WAYS");
   end

   logic [WAYS-1:0]        valid_q, res_q, cmp_q;
   logic [WAYS*TAG_W-1:0]  tag_flat;
   logic [WAYS*SZ_W-1:0]   size_flat;
   logic [WAYS*PERM_W-1:0] perm_flat;
   logic [WAYS*IDX_W-1:0]  pos_flat, owner_flat;
   logic [WAYS-1:0]        evict;

   logic             match_any;
   logic [IDX_W-1:0] match_idx;
   logic             free_any;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] target_idx;
   logic             do_fill, touch;
   logic             size_ok;
   logic             new_cmp;
   logic [SZ_W-1:0]  new_size;
   look_kind_e       kind_now;

   cset_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
      .valid (valid_q),
      .tags  (tag_flat),
      .key   (req_tag),
      .any   (match_any),
      .idx   (match_idx)
   );

   always_comb begin
      free_idx = '0;
      for (int w = WAYS-1; w >= 0; w--) begin
         if (!valid_q[w]) free_idx = IDX_W'(w);
      end
   end
   assign free_any = ~&valid_q;

   assign target_idx = match_any ? match_idx :
                       free_any  ? free_idx  :
                                   owner_flat[(WAYS-1)*IDX_W +: IDX_W];

   // size sanitising: only a compressed line shorter than a full line keeps its size
   assign size_ok  = req_cmp && (req_size != '0) && (req_size < SZ_W'(LINE_SEGS));
   assign new_cmp  = size_ok;
   assign new_size = size_ok ? req_size : SZ_W'(LINE_SEGS);

   assign do_fill = req_valid && req_fill;
   assign touch   = req_valid && (req_fill || match_any);

   cset_recency #(.WAYS(WAYS)) u_recency (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch      (touch),
      .touch_idx  (req_fill ? target_idx : match_idx),
      .pos_flat   (pos_flat),
      .owner_flat (owner_flat)
   );

   cset_space_plan #(.WAYS(WAYS), .SEGS(SEGS), .SZ_W(SZ_W)) u_plan (
      .resident   (res_q),
      .size_flat  (size_flat),
      .owner_flat (owner_flat),
      .target     (target_idx),
      .new_size   (new_size),
      .evict      (evict)
   );

   for (genvar w = 0; w < WAYS; w++) begin : g_entry
      logic              v_r, r_r, c_r;
      logic [TAG_W-1:0]  t_r;
      logic [SZ_W-1:0]   s_r;
      logic [PERM_W-1:0] p_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_r <= 1'b0;
            r_r <= 1'b0;
            c_r <= 1'b0;
            t_r <= '0;
            s_r <= '0;
            p_r <= '0;
         end else if (do_fill) begin
            if (target_idx == IDX_W'(w)) begin
               v_r <= 1'b1;
               r_r <= 1'b1;
               c_r <= new_cmp;
               t_r <= req_tag;
               s_r <= new_size;
               p_r <= req_perm;
            end else if (evict[w]) begin
               r_r <= 1'b0;
            end
         end
      end

      assign valid_q[w]                   = v_r;
      assign res_q[w]                     = r_r;
      assign cmp_q[w]                     = c_r;
      assign tag_flat[w*TAG_W +: TAG_W]   = t_r;
      assign size_flat[w*SZ_W +: SZ_W]    = s_r;
      assign perm_flat[w*PERM_W +: PERM_W] = p_r;
   end

   always_comb begin
      if (!match_any)          kind_now = KIND_TAG_MISS;
      else if (res_q[match_idx]) kind_now = KIND_HIT;
      else                     kind_now = KIND_DATA_ABSENT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_kind  <= KIND_TAG_MISS;
         rsp_depth <= '0;
         rsp_cmp   <= 1'b0;
         rsp_size  <= '0;
         rsp_perm  <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_kind  <= kind_now;
            rsp_depth <= match_any ? pos_flat[match_idx*IDX_W +: IDX_W] : '0;
            if (req_fill) begin
               rsp_cmp  <= new_cmp;
               rsp_size <= new_size;
               rsp_perm <= req_perm;
            end else if (match_any) begin
               rsp_cmp  <= cmp_q[match_idx];
               rsp_size <= size_flat[match_idx*SZ_W +: SZ_W];
               rsp_perm <= perm_flat[match_idx*PERM_W +: PERM_W];
            end else begin
               rsp_cmp  <= 1'b0;
               rsp_size <= '0;
               rsp_perm <= '0;
            end
         end
      end
   end

   always_comb begin
      int acc;
      acc = 0;
      for (int w = 0; w < WAYS; w++) begin
         if (res_q[w]) acc = acc + int'(size_flat[w*SZ_W +: SZ_W]);
      end
      seg_used = USE_W'(acc);
   end
endmodule

// File: rtl/cset_segment_set_chk.sv
module cset_segment_set_chk #(
   parameter int WAYS      = 4,
   parameter int SEGS      = 16,
   parameter int LINE_SEGS = 8,
   parameter int SZ_W      = 4,
   parameter int IDX_W     = 2,
   parameter int USE_W     = 5
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_fill,
   input logic                  rsp_valid,
   input logic [1:0]            rsp_kind,
   input logic                  rsp_cmp,
   input logic [SZ_W-1:0]       rsp_size,
   input logic [USE_W-1:0]      seg_used,
   input logic [WAYS*IDX_W-1:0] pos_flat
);
   logic [WAYS-1:0] seen;

   always_comb begin
      seen = '0;
      for (int w = 0; w < WAYS; w++) seen[pos_flat[w*IDX_W +: IDX_W]] = 1'b1;
   end

   p_used_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(seg_used) <= SEGS);

   p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_kind_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_kind != 2'd3));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && $stable(seg_used)));

   p_lookup_keeps_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_fill) |=> $stable(seg_used));

   p_stack_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(seen) == WAYS);

   p_size_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_kind != 2'd0) |->
         (rsp_size != '0 && int'(rsp_size) <= LINE_SEGS &&
          !(rsp_cmp && int'(rsp_size) == LINE_SEGS)));
endmodule

bind cset_segment_set cset_segment_set_chk #(
   .WAYS(WAYS), .SEGS(SEGS), .LINE_SEGS(LINE_SEGS),
   .SZ_W(SZ_W), .IDX_W(IDX_W), .USE_W(USE_W)
) u_chk (.*);

// File: tb/cset_segment_set_bench.sv
`timescale 1ns/1ps
module cset_segment_set_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_fill = 1'b0;
   logic [19:0] req_tag = '0;
   logic        req_cmp = 1'b0;
   logic [3:0]  req_size = '0;
   logic [1:0]  req_perm = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_kind;
   logic [1:0]  rsp_depth;
   logic        rsp_cmp;
   logic [3:0]  rsp_size;
   logic [1:0]  rsp_perm;
   logic [4:0]  seg_used;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   cset_segment_set u_cset_segment_set (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fill(req_fill),
      .req_tag(req_tag), .req_cmp(req_cmp), .req_size(req_size), .req_perm(req_perm),
      .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_depth(rsp_depth),
      .rsp_cmp(rsp_cmp), .rsp_size(rsp_size), .rsp_perm(rsp_perm), .seg_used(seg_used)
   );

   typedef struct packed {
      logic       fill;
      logic [3:0] tag;
      logic       cmp;
      logic [3:0] size;
      logic [1:0] perm;
      logic [1:0] ekind;
      logic [1:0] edepth;
      logic       ecmp;
      logic [3:0] esize;
      logic [1:0] eperm;
      logic [4:0] eused;
   } vec_t;

   // kind: 0 tag miss, 1 data absent, 2 hit; depth 0 = most recent
   localparam vec_t TBL [18] = '{
      '{1'b0, 4'd1, 1'b0, 4'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd0, 2'd0, 5'd0 },
      '{1'b1, 4'd1, 1'b0, 4'd3, 2'd1, 2'd0, 2'd0, 1'b0, 4'd8, 2'd1, 5'd8 },
      '{1'b1, 4'd2, 1'b1, 4'd2, 2'd2, 2'd0, 2'd0, 1'b1, 4'd2, 2'd2, 5'd10},
      '{1'b1, 4'd3, 1'b1, 4'd6, 2'd3, 2'd0, 2'd0, 1'b1, 4'd6, 2'd3, 5'd16},
      '{1'b1, 4'd4, 1'b1, 4'd4, 2'd0, 2'd0, 2'd0, 1'b1, 4'd4, 2'd0, 5'd12},
      '{1'b0, 4'd1, 1'b0, 4'd0, 2'd0, 2'd1, 2'd3, 1'b0, 4'd8, 2'd1, 5'd12},
      '{1'b0, 4'd2, 1'b0, 4'd0, 2'd0, 2'd2, 2'd3, 1'b1, 4'd2, 2'd2, 5'd12},
      '{1'b0, 4'd3, 1'b0, 4'd0, 2'd0, 2'd2, 2'd3, 1'b1, 4'd6, 2'd3, 5'd12},
      '{1'b0, 4'd3, 1'b0, 4'd0, 2'd0, 2'd2, 2'd0, 1'b1, 4'd6, 2'd3, 5'd12},
      '{1'b1, 4'd5, 1'b1, 4'd7, 2'd1, 2'd0, 2'd0, 1'b1, 4'd7, 2'd1, 5'd15},
      '{1'b0, 4'd4, 1'b0, 4'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd0, 2'd0, 5'd15},
      '{1'b1, 4'd1, 1'b0, 4'd8, 2'd2, 2'd1, 2'd3, 1'b0, 4'd8, 2'd2, 5'd15},
      '{1'b0, 4'd3, 1'b0, 4'd0, 2'd0, 2'd1, 2'd2, 1'b1, 4'd6, 2'd3, 5'd15},
      '{1'b0, 4'd5, 1'b0, 4'd0, 2'd0, 2'd2, 2'd2, 1'b1, 4'd7, 2'd1, 5'd15},
      '{1'b1, 4'd1, 1'b1, 4'd8, 2'd0, 2'd2, 2'd2, 1'b0, 4'd8, 2'd0, 5'd15},
      '{1'b1, 4'd6, 1'b1, 4'd0, 2'd0, 2'd0, 2'd0, 1'b0, 4'd8, 2'd0, 5'd16},
      '{1'b0, 4'd5, 1'b0, 4'd0, 2'd0, 2'd1, 2'd2, 1'b1, 4'd7, 2'd1, 5'd16},
      '{1'b0, 4'd6, 1'b0, 4'd0, 2'd0, 2'd2, 2'd1, 1'b0, 4'd8, 2'd0, 5'd16}
   };

   task automatic check(input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", what, got, exp);
      end
   endtask

   task automatic issue(input logic fill, input int tag, input logic cmp,
                        input int size, input int perm);
      @(negedge clk);
      req_valid = 1'b1;
      req_fill  = fill;
      req_tag   = 20'(tag);
      req_cmp   = cmp;
      req_size  = 4'(size);
      req_perm  = 2'(perm);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic check_rsp(input int i, input int kind, input int depth, input int cmp,
                            input int size, input int perm, input int used);
      check($sformatf("R2 rsp_valid step %0d", i), int'(rsp_valid), 1);
      check($sformatf("R2 R4 R5 kind step %0d", i), int'(rsp_kind), kind);
      check($sformatf("R6 depth step %0d", i), int'(rsp_depth), depth);
      check($sformatf("R7 R8 cmp step %0d", i), int'(rsp_cmp), cmp);
      check($sformatf("R7 R8 size step %0d", i), int'(rsp_size), size);
      check($sformatf("R8 perm step %0d", i), int'(rsp_perm), perm);
      check($sformatf("R3 R4 seg_used step %0d", i), int'(seg_used), used);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 rsp_valid at reset", int'(rsp_valid), 0);
      check("R1 seg_used at reset", int'(seg_used), 0);
      rst_n = 1'b1;

      // table walk: fills, evictions, data-absent matches, stack order
      for (int i = 0; i < 18; i++) begin
         issue(TBL[i].fill, int'(TBL[i].tag), TBL[i].cmp, int'(TBL[i].size), int'(TBL[i].perm));
         check_rsp(i, int'(TBL[i].ekind), int'(TBL[i].edepth), int'(TBL[i].ecmp),
                   int'(TBL[i].esize), int'(TBL[i].eperm), int'(TBL[i].eused));
      end

      // R9: idle cycle changes nothing and gives no response
      @(negedge clk);
      check("R9 rsp_valid after idle", int'(rsp_valid), 0);
      check("R9 seg_used after idle", int'(seg_used), 16);
      // R6: tag 6 remains most recent after the idle cycle
      issue(1'b0, 6, 1'b0, 0, 0);
      check_rsp(100, 2, 0, 0, 8, 0, 16);

      // R1: reset mid-run clears every tag
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 seg_used after reset", int'(seg_used), 0);
      check("R1 rsp_valid after reset", int'(rsp_valid), 0);
      rst_n = 1'b1;
      issue(1'b0, 6, 1'b0, 0, 0);
      check_rsp(101, 0, 0, 0, 0, 0, 0);

      // R7: compressed fill with an out-of-range size is stored uncompressed
      issue(1'b1, 7, 1'b1, 9, 3);
      check_rsp(102, 0, 0, 0, 8, 3, 8);
      issue(1'b0, 7, 1'b0, 0, 0);
      check_rsp(103, 2, 0, 0, 8, 3, 8);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule